// File: doc/BRIEF.md
# Configuration Stream Header Detector

The block scans an incoming byte stream for the fixed 13-word preamble that opens a device configuration image. The preamble may start at any byte position, not only on a 32-bit boundary. The block also decides whether the image is in natural or byte-reversed word order. It reports one found pulse, a swap flag and the byte offset where the preamble starts. It then turns every following group of four bytes into a 32-bit word. Each word is assembled in the detected order and marked by a valid strobe.

The preamble consists of four parts in this order:
- eight all-ones words;
- the sync words 0x000000BB and 0x11220044;
- two more all-ones words;
- the sync word 0xAA995566.

The all-ones words read the same in either byte order, so only the three sync words decide the order. A host pulses the clear input to start a new search. It raises the end-of-stream input when no more bytes will come, and the block then reports a miss if no preamble was seen.

Top module: `cfg_hdr_detect`

## Requirements
- R1: After reset, found_o, swap_o, miss_o and word_vld_o are 0 and offset_o is 0.
- R2: A natural-order preamble raises found_o for exactly one cycle, in the cycle after the edge that takes its last byte, with swap_o = 0. found_o fires at most once per search, even if the payload contains another preamble.
- R3: offset_o gives the zero-based index of the first preamble byte. Bytes are counted from the last reset or clear. Both offset_o and swap_o hold until the next clear.
- R4: A word of the preamble matches if its bytes taken first-byte-as-MSB equal the expected word, or if they equal its byte reversal. swap_o is 1 when any of the three sync words (words 8, 9 and 12, counting from 0) matched only in reversed order.
- R5: A candidate that fails at any word is dropped, and the search goes on from the next byte. The earliest byte position that starts a full preamble is the one reported, even when it overlaps a rejected candidate.
- R6: A stream whose preamble has a wrong byte never raises found_o.
- R7: After found_o, each group of four bytes gives one word_vld_o pulse, in the cycle after the edge that takes the fourth byte. In natural order the first byte of the group is word_o[31:24] and the fourth byte is word_o[7:0].
- R8: When swap_o is 1, the first byte of each group is word_o[7:0] and the fourth byte is word_o[31:24].
- R9: If eos_i is high while the block is still searching, miss_o rises and stays high until a clear. Bytes that follow are ignored, with no found_o and no word_vld_o. If eos_i is high after the preamble was found, it has no effect.
- R10: While start_i is high, the byte on the input is discarded. At the next edge, all outputs return to their reset values and the bytes seen before the clear are forgotten.
- R11: A byte is taken only on an edge where in_vld_i is 1. Idle cycles between bytes do not change detection, offset or word assembly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear and restart the search |
| in_vld_i | input | 1 | Input byte valid |
| in_byte_i | input | 8 | Input byte |
| eos_i | input | 1 | End of stream |
| found_o | output | 1 | One-cycle pulse when the preamble is accepted |
| swap_o | output | 1 | Byte-reversed word order detected |
| offset_o | output | OFF_W | Byte index of the preamble start |
| miss_o | output | 1 | Stream ended without a preamble |
| word_vld_o | output | 1 | Output word valid |
| word_o | output | 32 | Realigned payload word |

## Verification
The assertions check, on every cycle, the following timing rules:
- found_o lasts one cycle;
- swap_o and offset_o hold while words are streaming;
- the miss state is sticky and never shows together with found_o or a word strobe;
- a clear returns every output to its reset value;
- two word strobes never fall on back-to-back cycles.

Only the bench scenarios can show the search itself:
- the earliest start is chosen after an overlapping rejected candidate;
- the reported offset is correct;
- the order decision comes from the sync words;
- payload bytes land in the right lanes in both orders;
- input gaps, corrupted preambles and clears in mid-preamble are handled correctly.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = WORD_BYTES * 8;
  localparam int PRE_WORDS  = 13;

  typedef enum logic [1:0] {ST_SEARCH, ST_STREAM, ST_MISS} hdr_state_e;

  function automatic logic [WORD_W-1:0] exp_word(input int idx);
    case (idx)
      8:       return 32'h0000_00BB;
      9:       return 32'h1122_0044;
      12:      return 32'hAA99_5566;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_BYTES; b++) r[b*8 +: 8] = w[(WORD_BYTES-1-b)*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cfg_hdr_window.sv
module cfg_hdr_window #(
  parameter int WIN_BYTES = 52
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   shift_i,
  input  logic [7:0]             byte_i,
  output logic [WIN_BYTES*8-1:0] win_nxt_o
);
  localparam int WIN_W = WIN_BYTES * 8;

  logic [WIN_W-1:0] win_q;

  // newest byte sits in the low lane; oldest in the top lane
  assign win_nxt_o = {win_q[WIN_W-9:0], byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q <= '0;
    else if (clr_i)   win_q <= '0;
    else if (shift_i) win_q <= win_nxt_o;
  end
endmodule

// File: rtl/cfg_hdr_match.sv
module cfg_hdr_match
  import cfg_hdr_pkg::*;
#(
  parameter int N_WORDS = PRE_WORDS
) (
  input  logic [N_WORDS*WORD_W-1:0] win_i,
  output logic                      hit_o,
  output logic                      swap_o
);
  logic [N_WORDS-1:0] nat_ok, rev_ok;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    localparam logic [WORD_W-1:0] EXP = exp_word(g);
    // word g of the stream: oldest byte is the MSB
    logic [WORD_W-1:0] w;
    assign w         = win_i[(N_WORDS-1-g)*WORD_W +: WORD_W];
    assign nat_ok[g] = (w == EXP);
    assign rev_ok[g] = (byte_rev(w) == EXP);
  end

  assign hit_o  = &(nat_ok | rev_ok);
  // all-ones words match both ways and so never vote for swap
  assign swap_o = |(rev_ok & ~nat_ok);
endmodule

// File: rtl/cfg_hdr_pack.sv
module cfg_hdr_pack
  import cfg_hdr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              vld_i,
  input  logic [7:0]        byte_i,
  input  logic              swap_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_BYTES);
  localparam int ACC_W = (WORD_BYTES - 1) * 8;

  logic [CNT_W-1:0]  cnt_q;
  logic [ACC_W-1:0]  acc_q;
  logic [WORD_W-1:0] nat_w, swp_w;
  logic              last;

  assign nat_w = {acc_q, byte_i};
  assign last  = (cnt_q == CNT_W'(WORD_BYTES - 1));

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_rev
    assign swp_w[g*8 +: 8] = nat_w[(WORD_BYTES-1-g)*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      acc_q      <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
        acc_q <= '0;
      end else if (vld_i) begin
        acc_q <= nat_w[ACC_W-1:0];
        if (last) begin
          cnt_q      <= '0;
          word_vld_o <= 1'b1;
          word_o     <= swap_i ? swp_w : nat_w;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_WORD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o); // R7
endmodule

// File: rtl/cfg_hdr_detect.sv
module cfg_hdr_detect
  import cfg_hdr_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              in_vld_i,
  input  logic [7:0]        in_byte_i,
  input  logic              eos_i,
  output logic              found_o,
  output logic              swap_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              miss_o,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int WIN_BYTES = PRE_WORDS * WORD_BYTES;

  hdr_state_e                state_q;
  logic [OFF_W-1:0]          cnt_q;
  logic [WIN_BYTES*8-1:0]    win_nxt;
  logic                      searching, streaming, take, m_hit, m_swap;

  assign searching = (state_q == ST_SEARCH);
  assign streaming = (state_q == ST_STREAM);
  assign take      = in_vld_i && !start_i && searching;
  assign miss_o    = (state_q == ST_MISS);

  cfg_hdr_window #(.WIN_BYTES(WIN_BYTES)) u_win (
    .clk_i, .rst_ni,
    .clr_i    (start_i),
    .shift_i  (take),
    .byte_i   (in_byte_i),
    .win_nxt_o(win_nxt)
  );

  cfg_hdr_match #(.N_WORDS(PRE_WORDS)) u_match (
    .win_i (win_nxt),
    .hit_o (m_hit),
    .swap_o(m_swap)
  );

  cfg_hdr_pack u_pack (
    .clk_i, .rst_ni,
    .clr_i     (start_i || !streaming),
    .vld_i     (in_vld_i && streaming && !start_i),
    .byte_i    (in_byte_i),
    .swap_i    (swap_o),
    .word_vld_o(word_vld_o),
    .word_o    (word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_SEARCH;
      cnt_q    <= '0;
      found_o  <= 1'b0;
      swap_o   <= 1'b0;
      offset_o <= '0;
    end else begin
      found_o <= 1'b0;
      if (start_i) begin
        state_q  <= ST_SEARCH;
        cnt_q    <= '0;
        swap_o   <= 1'b0;
        offset_o <= '0;
      end else if (searching) begin
        if (in_vld_i) cnt_q <= cnt_q + 1'b1;
        if (take && m_hit) begin
          state_q  <= ST_STREAM;
          found_o  <= 1'b1;
          swap_o   <= m_swap;
          // current byte is the last of the window
          offset_o <= cnt_q - OFF_W'(WIN_BYTES - 1);
        end else if (eos_i) begin
          state_q <= ST_MISS;
        end
      end
    end
  end

  AST_FOUND_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |=> !found_o); // R2
  AST_STREAM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (streaming && !start_i) |=> ($stable(swap_o) && $stable(offset_o))); // R3
  AST_MISS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_o && !start_i) |=> miss_o); // R9
  AST_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (!found_o && !word_vld_o)); // R6
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!found_o && !miss_o && !swap_o && !word_vld_o && offset_o == '0)); // R10
endmodule

// File: tb/tb_cfg_hdr_detect.sv
module tb_cfg_hdr_detect;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        in_vld_i = 1'b0;
  logic [7:0]  in_byte_i = '0;
  logic        eos_i = 1'b0;
  logic        found_o, swap_o, miss_o, word_vld_o;
  logic [15:0] offset_o;
  logic [31:0] word_o;

  int checks = 0;
  int errors = 0;
  int n_found = 0;
  int n_words = 0;
  logic [15:0] f_off;
  logic        f_swp;
  logic [31:0] words [0:31];

  always #5 clk_i = ~clk_i;

  cfg_hdr_detect dut (.*);

  always @(negedge clk_i) begin
    if (found_o) begin
      n_found++;
      f_off = offset_o;
      f_swp = swap_o;
    end
    if (word_vld_o) begin
      if (n_words < 32) words[n_words] = word_o;
      n_words++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pre_byte(input int k, input bit sw);
    logic [31:0] e;
    int b;
    case (k / 4)
      8:       e = 32'h0000_00BB;
      9:       e = 32'h1122_0044;
      12:      e = 32'hAA99_5566;
      default: e = 32'hFFFF_FFFF;
    endcase
    b = k % 4;
    return sw ? e[8*b +: 8] : e[8*(3-b) +: 8];
  endfunction

  task automatic put(input logic [7:0] b);
    in_vld_i  = 1'b1;
    in_byte_i = b;
    @(negedge clk_i);
    in_vld_i  = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_pre(input bit sw, input bit bad, input int gap);
    for (int k = 0; k < 52; k++) begin
      put((bad && k == 51) ? (pre_byte(k, sw) ^ 8'h01) : pre_byte(k, sw));
      if (gap > 0) idle(gap);
    end
  endtask

  task automatic clear();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n_found = 0;
    n_words = 0;
  endtask

  task automatic t_reset();
    chk(!found_o && !swap_o && !miss_o && !word_vld_o, "R1 flags", {found_o, swap_o, miss_o, word_vld_o}, 0);
    chk(offset_o == 0, "R1 offset", offset_o, 0);
  endtask

  task automatic t_natural();
    clear();
    send_pre(0, 0, 0);
    for (int i = 1; i <= 8; i++) put(8'(i));
    idle(2);
    chk(n_found == 1, "R2 found once", n_found, 1);
    chk(f_swp == 0, "R2 swap", f_swp, 0);
    chk(f_off == 0, "R3 offset zero", f_off, 0);
    chk(n_words == 2, "R7 word count", n_words, 2);
    chk(words[0] == 32'h01020304, "R7 word0", words[0], 32'h01020304);
    chk(words[1] == 32'h05060708, "R7 word1", words[1], 32'h05060708);
  endtask

  task automatic t_swapped_offset();
    clear();
    put(8'h12); put(8'h34); put(8'h56); put(8'hFF); put(8'hFF);
    send_pre(1, 0, 0);
    for (int i = 1; i <= 8; i++) put(8'(i));
    idle(2);
    chk(n_found == 1, "R4 found", n_found, 1);
    chk(f_swp == 1, "R4 swap", f_swp, 1);
    chk(f_off == 5, "R3 offset five", f_off, 5);
    chk(swap_o == 1 && offset_o == 5, "R3 hold", {swap_o, offset_o}, {1'b1, 16'd5});
    chk(words[0] == 32'h04030201, "R8 word0", words[0], 32'h04030201);
    chk(words[1] == 32'h08070605, "R8 word1", words[1], 32'h08070605);
  endtask

  task automatic t_overlap();
    clear();
    put(8'hFF); put(8'hFF); put(8'hFF);
    send_pre(0, 0, 0);
    idle(2);
    chk(n_found == 1, "R5 found", n_found, 1);
    chk(f_off == 3, "R5 earliest start", f_off, 3);
  endtask

  task automatic t_gaps();
    clear();
    put(8'h00); idle(3); put(8'h00);
    send_pre(0, 0, 1);
    put(8'hA1); idle(2); put(8'hB2); put(8'hC3); idle(1); put(8'hD4);
    idle(2);
    chk(n_found == 1 && f_off == 2, "R11 offset with gaps", f_off, 2);
    chk(n_words == 1 && words[0] == 32'hA1B2C3D4, "R11 word with gaps", words[0], 32'hA1B2C3D4);
  endtask

  task automatic t_corrupt_miss();
    clear();
    send_pre(0, 1, 0);
    idle(2);
    chk(n_found == 0, "R6 corrupt not found", n_found, 0);
    chk(miss_o == 0, "R9 no miss before eos", miss_o, 0);
    eos_i = 1'b1; @(negedge clk_i); eos_i = 1'b0;
    chk(miss_o == 1, "R9 miss raised", miss_o, 1);
    send_pre(0, 0, 0);
    put(8'h01); put(8'h02); put(8'h03); put(8'h04);
    idle(2);
    chk(miss_o == 1, "R9 miss held", miss_o, 1);
    chk(n_found == 0 && n_words == 0, "R9 bytes ignored", n_found + n_words, 0);
  endtask

  task automatic t_clear_mid();
    clear();
    for (int k = 0; k < 26; k++) put(pre_byte(k, 0));
    clear();
    for (int k = 26; k < 52; k++) put(pre_byte(k, 0));
    idle(2);
    chk(n_found == 0, "R10 split not found", n_found, 0);
    send_pre(0, 0, 0);
    idle(2);
    chk(n_found == 1 && f_off == 26, "R10 offset from clear", f_off, 26);
    clear();
    chk(!found_o && !swap_o && !miss_o && offset_o == 0, "R10 outputs cleared", offset_o, 0);
  endtask

  task automatic t_eos_after();
    clear();
    send_pre(0, 0, 0);
    eos_i = 1'b1; @(negedge clk_i); eos_i = 1'b0;
    send_pre(0, 0, 0);
    put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    idle(2);
    chk(miss_o == 0, "R9 eos ignored after found", miss_o, 0);
    chk(n_found == 1, "R2 no second found", n_found, 1);
    chk(n_words == 14, "R7 payload words", n_words, 14);
    chk(words[8] == 32'h000000BB, "R7 payload sync", words[8], 32'h000000BB);
    chk(words[13] == 32'h11223344, "R7 payload tail", words[13], 32'h11223344);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    t_reset();
    t_natural();
    t_swapped_offset();
    t_overlap();
    t_gaps();
    t_corrupt_miss();
    t_clear_mid();
    t_eos_after();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule